// File: doc/BRIEF.md
# Flash Program/Erase Command Sequencer

This block is the embedded command engine of a small synchronous flash array. It watches the write bus for multi-cycle unlock sequences. A complete sequence either programs one word or erases one of eight equal sectors. When the final cycle of a sequence is accepted, the block latches the target, raises `busy` and counts a fixed number of clock cycles. When the count ends, it updates the array in one step.

Programming can only clear bits, so the stored word becomes the old value ANDed with the new data. Erase fills every word of the chosen sector with ones. While an operation runs, every write is dropped. A read during that time returns a status word in which bit 7 is the complement of bit 7 of the value being written. When the operation is over, reads return the stored contents again.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `busy` is 0, `rdData` is 0 and every array word reads as all ones.
- R2: Word program is four write cycles on consecutive or separated `wrEn` cycles:
  - (555h, AAh), then (2AAh, 55h), then (555h, A0h), then (target address, data).
  - Addresses are compared on all 12 bits.
  - Only data bits [7:0] are compared; bits [31:8] are don't-care.
- R3: A completed program leaves word `addr[5:0]` equal to its old value ANDed with the programmed data. Address bits [11:6] of the target cycle are ignored.
- R4: Sector erase is six write cycles:
  - (555h, AAh), (2AAh, 55h), (555h, 80h), (555h, AAh), (2AAh, 55h), then (any address, 30h) in the low byte.
  - Sector `addr[5:3]` of the last cycle has all eight of its words set to all ones.
  - Every other word is unchanged.
- R5: `busy` rises on the clock edge that samples the final cycle of a sequence. It stays high for exactly PROG_CYC cycles (program) or ERASE_CYC cycles (erase). The array update lands on the edge where `busy` falls.
- R6: A write whose address or low data byte does not match the step expected returns the sequencer to idle. It does not change the array and does not raise `busy`. The mismatching cycle does not itself begin a new sequence.
- R7: Every write presented while `busy` is high is ignored, including complete program or erase sequences.
- R8: A read (`rdEn` high on a clock edge) updates `rdData` on that edge. When `busy` is low, `rdData` becomes the word at `addr[5:0]`; otherwise `rdData` holds its value.
- R9: A read while `busy` is high returns a status word in which:
  - all bits are 0 except bit 7;
  - bit 7 is the complement of bit 7 of the target value, which is the program data, or all ones for an erase (so an erase reads 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write cycle strobe for command sequences |
| rdEn | input | 1 | Read strobe |
| addr | input | 12 | Word address for reads and writes |
| wrData | input | 32 | Write data; low byte carries command codes |
| rdData | output | 32 | Registered read data or polling status |
| busy | output | 1 | High while a program or erase is in progress |

## Verification
The assertions assume that `wrEn` and `rdEn` are never used to begin a second operation before `busy` has fallen. They also assume that `addr` and `wrData` are stable at each sampling edge, which holds because the bench drives all inputs on the falling edge. The stimulus keeps to the legal window by deriving every post-start action from a cycle count since the start edge:
- status reads and lockout writes are placed before the busy window closes;
- a later operation is issued only after `busy` has been seen low;
- aborted sequences are cut off at the corrupted cycle, so a stray remainder never forms a valid prefix.

// File: rtl/flash_seq_pkg.sv
`timescale 1ns/1ps
package flash_seq_pkg;

  localparam logic [11:0] KEY_ADDR_A  = 12'h555;
  localparam logic [11:0] KEY_ADDR_B  = 12'h2AA;
  localparam logic [7:0]  KEY_FIRST   = 8'hAA;
  localparam logic [7:0]  KEY_SECOND  = 8'h55;
  localparam logic [7:0]  KEY_PROGRAM = 8'hA0;
  localparam logic [7:0]  KEY_ERASE   = 8'h80;
  localparam logic [7:0]  KEY_CONFIRM = 8'h30;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GOT1,
    ST_GOT2,
    ST_PGM,
    ST_ER3,
    ST_ER4,
    ST_ER5,
    ST_BUSY
  } seqState_t;

  typedef struct packed {
    logic latch;    // capture target this cycle
    logic commit;   // apply update this cycle
    logic opErase;  // operation kind for latch/commit/poll
    logic busy;     // operation in progress
  } seqStrb_t;

endpackage

// File: rtl/flash_seq_ctrl.sv
`timescale 1ns/1ps
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned PROG_CYC  = 8,
  parameter int unsigned ERASE_CYC = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        cmdByte,
  output seqStrb_t          strb
);

  localparam int unsigned MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  seqState_t        state, stateNext;
  logic [CNT_W-1:0] cnt;
  logic             opReg;
  logic             isKeyA, isKeyB, latchNow, commitNow;

  assign isKeyA = (addr == ADDR_W'(KEY_ADDR_A));
  assign isKeyB = (addr == ADDR_W'(KEY_ADDR_B));

  always_comb begin
    stateNext = state;
    latchNow  = 1'b0;
    unique case (state)
      ST_IDLE: if (wrEn) stateNext = (isKeyA && cmdByte == KEY_FIRST) ? ST_GOT1 : ST_IDLE;
      ST_GOT1: if (wrEn) stateNext = (isKeyB && cmdByte == KEY_SECOND) ? ST_GOT2 : ST_IDLE;
      ST_GOT2: if (wrEn) begin
        if (isKeyA && cmdByte == KEY_PROGRAM)    stateNext = ST_PGM;
        else if (isKeyA && cmdByte == KEY_ERASE) stateNext = ST_ER3;
        else                                     stateNext = ST_IDLE;
      end
      ST_PGM: if (wrEn) begin
        stateNext = ST_BUSY;
        latchNow  = 1'b1;
      end
      ST_ER3: if (wrEn) stateNext = (isKeyA && cmdByte == KEY_FIRST) ? ST_ER4 : ST_IDLE;
      ST_ER4: if (wrEn) stateNext = (isKeyB && cmdByte == KEY_SECOND) ? ST_ER5 : ST_IDLE;
      ST_ER5: if (wrEn) begin
        if (cmdByte == KEY_CONFIRM) begin
          stateNext = ST_BUSY;
          latchNow  = 1'b1;
        end else begin
          stateNext = ST_IDLE;
        end
      end
      ST_BUSY: if (cnt == CNT_W'(1)) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign commitNow = (state == ST_BUSY) && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      opReg <= 1'b0;
    end else begin
      state <= stateNext;
      if (latchNow) begin
        cnt   <= (state == ST_ER5) ? CNT_W'(ERASE_CYC) : CNT_W'(PROG_CYC);
        opReg <= (state == ST_ER5);
      end else if (state == ST_BUSY) begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  assign strb.latch   = latchNow;
  assign strb.commit  = commitNow;
  assign strb.busy    = (state == ST_BUSY);
  assign strb.opErase = (state == ST_BUSY) ? opReg : (state == ST_ER5);

  initial begin
    cyc_param_chk: assert (PROG_CYC >= 1 && ERASE_CYC >= 1);
  end

  // R5
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strb.busy) |-> $past(strb.commit));

  // R5
  commit_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> strb.busy);

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.busy && !strb.commit |=> strb.busy && $stable(strb.opErase));

  // R6
  start_only_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.busy && !strb.latch |=> !strb.busy);

endmodule

// File: rtl/flash_seq_dp.sv
`timescale 1ns/1ps
module flash_seq_dp
  import flash_seq_pkg::*;
#(
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned SECTORS       = 8,
  parameter int unsigned WORDS_PER_SEC = 8,
  localparam int unsigned DEPTH = SECTORS * WORDS_PER_SEC,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrb_t          strb,
  input  logic              rdEn,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  localparam int unsigned WPS_W = $clog2(WORDS_PER_SEC);
  localparam int unsigned SEC_W = IDX_W - WPS_W;

  logic [IDX_W-1:0]  tgtIdx;
  logic [DATA_W-1:0] tgtData;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] pollWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtIdx  <= '0;
      tgtData <= '1;
    end else if (strb.latch) begin
      tgtIdx  <= idx;
      tgtData <= strb.opErase ? '1 : wrData;
    end
  end

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic [DATA_W-1:0] wordQ;
    logic              hitSec, hitWord;
    assign hitSec  = (tgtIdx[IDX_W-1:WPS_W] == SEC_W'(w / WORDS_PER_SEC));
    assign hitWord = (tgtIdx == IDX_W'(w));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        wordQ <= '1;
      end else if (strb.commit) begin
        if (strb.opErase && hitSec)        wordQ <= '1;
        else if (!strb.opErase && hitWord) wordQ <= wordQ & tgtData;
      end
    end
    assign mem[w] = wordQ;
  end

  always_comb begin
    pollWord    = '0;
    pollWord[7] = ~tgtData[7];
  end

  always_ff @(posedge clk) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= strb.busy ? pollWord : mem[idx];
  end

  // R3
  prog_and_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit && !strb.opErase |=>
      mem[$past(tgtIdx)] == ($past(mem[tgtIdx]) & $past(tgtData)));

  // R4
  erase_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit && strb.opErase |=>
      mem[{$past(tgtIdx[IDX_W-1:WPS_W]), {WPS_W{1'b0}}}] == '1 &&
      mem[{$past(tgtIdx[IDX_W-1:WPS_W]), {WPS_W{1'b1}}}] == '1);

  // R7
  tgt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.busy |=> $stable(tgtData) && $stable(tgtIdx));

  // R9
  poll_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && strb.busy |=> rdData[7] != $past(tgtData[7]) && rdData[6:0] == '0);

endmodule

// File: rtl/flash_cmd_seq.sv
`timescale 1ns/1ps
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int unsigned ADDR_W        = 12,
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned SECTORS       = 8,
  parameter int unsigned WORDS_PER_SEC = 8,
  parameter int unsigned PROG_CYC      = 8,
  parameter int unsigned ERASE_CYC     = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              busy
);

  localparam int unsigned IDX_W = $clog2(SECTORS * WORDS_PER_SEC);

  seqStrb_t strb;

  flash_seq_ctrl #(
    .ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .cmdByte(wrData[7:0]), .strb(strb)
  );

  flash_seq_dp #(
    .DATA_W(DATA_W), .SECTORS(SECTORS), .WORDS_PER_SEC(WORDS_PER_SEC)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .rdEn(rdEn),
    .idx(addr[IDX_W-1:0]), .wrData(wrData), .rdData(rdData)
  );

  assign busy = strb.busy;

endmodule

// File: tb/flash_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb_top;

  localparam int PROG_N  = 8;
  localparam int ERASE_N = 40;
  localparam int DEPTH   = 64;

  logic        clk = 1'b0;
  logic        rstN, wrEn, rdEn;
  logic [11:0] addr;
  logic [31:0] wrData, rdData;
  logic        busy;

  int checks = 0;
  int errors = 0;
  int el = 0;
  logic [31:0] model [DEPTH];

  always #2.5 clk = ~clk;

  flash_cmd_seq #(.PROG_CYC(PROG_N), .ERASE_CYC(ERASE_N)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .busy(busy)
  );

  function automatic logic [31:0] pollExp(input logic [31:0] t);
    logic [31:0] p = '0;
    p[7] = ~t[7];
    return p;
  endfunction

  task automatic chkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; el++;
  endtask

  task automatic keyWr(input logic [11:0] a, input logic [7:0] k);
    wr(a, ($urandom() & 32'hFFFF_FF00) | {24'h0, k});
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0; el++;
    v = rdData;
  endtask

  task automatic waitTo(input int t);
    while (el < t) begin
      @(negedge clk);
      el++;
    end
  endtask

  // corruptAt < 0: full sequence; else stop after corrupted step
  task automatic sendSeq(input bit isErase, input int corruptAt,
                         input logic [11:0] tA, input logic [31:0] tD);
    logic [11:0] a [6];
    logic [7:0]  k [6];
    int n = isErase ? 6 : 4;
    a[0] = 12'h555; k[0] = 8'hAA;
    a[1] = 12'h2AA; k[1] = 8'h55;
    a[2] = 12'h555; k[2] = isErase ? 8'h80 : 8'hA0;
    a[3] = isErase ? 12'h555 : tA; k[3] = isErase ? 8'hAA : tD[7:0];
    a[4] = 12'h2AA; k[4] = 8'h55;
    a[5] = tA;      k[5] = 8'h30;
    for (int s = 0; s < n; s++) begin
      if (s == corruptAt) begin
        if (($urandom() % 2 == 0) && !(isErase && s == 5)) a[s] = a[s] ^ 12'h001;
        else k[s] = k[s] ^ 8'h01;
        keyWr(a[s], k[s]);
        return;
      end
      if (!isErase && s == 3) wr(tA, tD);
      else keyWr(a[s], k[s]);
    end
  endtask

  task automatic doProg(input logic [11:0] a, input logic [31:0] d,
                        input bit poll, input bit inject);
    logic [31:0] v;
    sendSeq(1'b0, -1, a, d);
    el = 0;
    chkEq("R5 busy after program start", {31'b0, busy}, 32'd1);
    if (poll) begin
      rd(12'($urandom()), v);
      chkEq("R9 program poll", v, pollExp(d));
    end
    if (inject) sendSeq(1'b0, -1, 12'($urandom()), $urandom());   // R7 ignored
    waitTo(PROG_N - 1);
    chkEq("R5 busy held to last program cycle", {31'b0, busy}, 32'd1);
    waitTo(PROG_N);
    chkEq("R5 busy low after program", {31'b0, busy}, 32'd0);
    model[a[5:0]] = model[a[5:0]] & d;
  endtask

  task automatic doErase(input logic [11:0] a, input bit poll, input bit inject);
    logic [31:0] v;
    sendSeq(1'b1, -1, a, 32'h0);
    el = 0;
    chkEq("R5 busy after erase start", {31'b0, busy}, 32'd1);
    if (poll) begin
      rd(12'($urandom()), v);
      chkEq("R9 erase poll", v, 32'h0);
    end
    if (inject) sendSeq(1'b1, -1, 12'($urandom()), 32'h0);        // R7 ignored
    waitTo(ERASE_N - 1);
    chkEq("R5 busy held to last erase cycle", {31'b0, busy}, 32'd1);
    waitTo(ERASE_N);
    chkEq("R5 busy low after erase", {31'b0, busy}, 32'd0);
    for (int w = 0; w < 8; w++) model[{a[5:3], 3'(w)}] = '1;
  endtask

  task automatic rdChk(input string tag, input logic [11:0] a);
    logic [31:0] v;
    rd(a, v);
    chkEq(tag, v, model[a[5:0]]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240607));
    rstN = 1'b0; wrEn = 1'b0; rdEn = 1'b0; addr = '0; wrData = '0;
    for (int i = 0; i < DEPTH; i++) model[i] = '1;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chkEq("R1 busy at reset", {31'b0, busy}, 32'd0);
    chkEq("R1 rdData at reset", rdData, 32'd0);
    rdChk("R1 word 0 erased", 12'h000);
    rdChk("R1 word 63 erased", 12'h03F);

    // R2/R3 program with ignored upper address bits, then AND behaviour
    doProg(12'hF05, 32'h1234_5678, 1'b1, 1'b0);
    rdChk("R3 first program", 12'h005);
    doProg(12'h005, 32'hFF00_FF0F, 1'b1, 1'b0);
    rdChk("R3 second program ANDs", 12'h045);
    chkEq("R3 expected AND value", model[5], 32'h1200_5608);
    rdChk("R2 neighbour untouched", 12'h004);

    // R6 abort mid-sequence, stray codes afterwards
    keyWr(12'h555, 8'hAA); keyWr(12'h2AA, 8'h54);
    wr(12'h555, 32'h0000_00A0); wr(12'h007, 32'h0);
    chkEq("R6 no busy after abort", {31'b0, busy}, 32'd0);
    rdChk("R6 word 7 unchanged", 12'h007);

    // R7 lockout during program
    doProg(12'h009, 32'h0000_0080, 1'b1, 1'b0);
    sendSeq(1'b0, -1, 12'h00A, 32'hFFFF_FF00);
    el = 0;
    sendSeq(1'b0, -1, 12'h00B, 32'h0);
    sendSeq(1'b0, -1, 12'h00A, 32'h0);
    waitTo(PROG_N);
    chkEq("R7 busy ended", {31'b0, busy}, 32'd0);
    model[10] = model[10] & 32'hFFFF_FF00;
    rdChk("R7 locked-out write ignored at 11", 12'h00B);
    rdChk("R7 locked-out write ignored at 10", 12'h00A);

    // R4 erase sector 1, check sector and neighbour
    for (int w = 8; w < 16; w++) doProg(12'(w), $urandom(), 1'b0, 1'b0);
    doErase(12'hA0C, 1'b1, 1'b1);
    for (int w = 8; w < 16; w++) rdChk("R4 sector word erased", 12'(w));
    rdChk("R4 other sector kept", 12'h005);

    // R6 erase aborts: wrong confirm, wrong address
    doProg(12'h011, 32'h0F0F_0F0F, 1'b0, 1'b0);
    sendSeq(1'b1, 5, 12'h011, 32'h0);
    chkEq("R6 bad confirm no busy", {31'b0, busy}, 32'd0);
    rdChk("R6 bad confirm no erase", 12'h011);
    sendSeq(1'b1, 4, 12'h011, 32'h0);
    chkEq("R6 bad address no busy", {31'b0, busy}, 32'd0);
    rdChk("R6 bad address no erase", 12'h011);

    // random mix
    for (int it = 0; it < 60; it++) begin
      int kind = int'($urandom() % 10);
      if (kind < 6) begin
        doProg(12'($urandom()), $urandom(), 1'($urandom()), 1'($urandom()));
      end else if (kind < 8) begin
        doErase(12'($urandom()), 1'($urandom()), 1'($urandom()));
      end else begin
        bit e = 1'($urandom());
        sendSeq(e, e ? int'($urandom() % 6) : int'($urandom() % 3),
                12'($urandom()), $urandom());
        chkEq("R6 random abort no busy", {31'b0, busy}, 32'd0);
      end
      rdChk("R8 random readback", 12'($urandom()));
    end

    // R8 full sweep
    for (int i = 0; i < DEPTH; i++) rdChk("R8 final sweep", 12'(i));
    rd(12'h001, v);
    addr = 12'h005;
    @(negedge clk);
    chkEq("R8 rdData holds without rdEn", rdData, model[1]);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule